// File: doc/BRIEF.md
# Isolated Real-Time Clock Request Bridge

This block is a real-time clock split into two parts. A bus-side register file of 16-bit registers faces software. Behind it sits an always-on store that holds a 32-bit seconds base, a 32-bit seconds counter, two 32-bit software words and a counter snapshot. Software never reaches the always-on store directly. It sets one request bit in the control register and loads the write halves when it has data to send. The isolation strobe, a single-cycle pulse, then carries the request across. Read results come back into a pair of read-data registers.

The time of day is the stored base plus the counter. To set the time, software first writes the base. It then clears the counter, which takes one strobe with the reset request set and a second strobe after that request is withdrawn. Last, it writes 1 to software word 0 to mark the clock valid. Reading the counter takes two steps. A strobe with the counter-read request set takes a snapshot. A later write of the trigger register copies that snapshot into the two count registers.

Register map (address: meaning): 0 control, 1 second control (bit 0 counter-read request), 2 trigger (write bit 0 = 1 to fire, reads 0), 3/4 write data low/high, 5/6 read data low/high, 7/8 count low/high. Addresses 9 and above read 0 and ignore writes.

Top module: `rtcb_top`

## Requirements
- R1: After reset every register reads 0, and a read of software word 0 returns 0 (time not valid).
- R2: A strobe with control bit 1 (base write) as the winning request loads the base with {write-data high, write-data low} as they stood before that clock edge.
- R3: A strobe with control bit 2, 7 or 8 as the winning request loads the read-data registers with the base, software word 0 or software word 1 respectively. Read data is visible after that edge.
- R4: A strobe with control bit 5 or 6 as the winning request loads software word 0 or 1 from the write-data pair.
- R5: The counter rises by one on each cycle with the seconds tick high.
- R6: A strobe with control bit 3 as the winning request clears the counter. A tick in that same cycle is lost.
- R7: A strobe with second-control bit 0 set and no control request bit set snapshots the counter. A write to the trigger register with bit 0 = 1 copies the snapshot into the count registers, which do not change at any other time.
- R8: Without a strobe, request bits change nothing in the always-on store or the read-data registers.
- R9: Among control bits 1, 2, 3, 5, 6, 7 and 8 the lowest set bit is the only one served at a strobe. Other control bits are ignored.
- R10: Control, second control and write-data registers read back their full 16-bit value. Writes to the read-data and count registers are ignored, and the trigger register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data, combinational on bus_addr |
| iso_strobe | input | 1 | Single-cycle isolation strobe that carries the pending request |
| sec_tick | input | 1 | One-cycle seconds tick |

## Verification
Directed sequences run the full set-time procedure, followed by ticks and a two-step counter read. Software can then form base plus count from register values alone. Conflict patterns set several request bits at once, or combine a counter-read request with a control request, so that a wrong winner shows up as a corrupted word or a stale snapshot. A reset strobe together with a tick tells apart "reset beats tick" from "tick after reset". Random mixes of register writes, strobes with and without requests, ticks, trigger writes and writes to read-only addresses catch stray updates that directed cases would not reach.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
   localparam int REQ_N     = 9;
   localparam int B_BASE_WR = 1;
   localparam int B_BASE_RD = 2;
   localparam int B_CNT_CLR = 3;
   localparam int B_SW0_WR  = 5;
   localparam int B_SW1_WR  = 6;
   localparam int B_SW0_RD  = 7;
   localparam int B_SW1_RD  = 8;
   localparam logic [REQ_N-1:0] REQ_MASK = 9'h1EE;
   localparam int SEL_W     = 4;

   typedef enum logic [SEL_W-1:0] {
      A_CTRL  = 4'd0,
      A_CTRL2 = 4'd1,
      A_TRIG  = 4'd2,
      A_WLO   = 4'd3,
      A_WHI   = 4'd4,
      A_RLO   = 4'd5,
      A_RHI   = 4'd6,
      A_CLO   = 4'd7,
      A_CHI   = 4'd8
   } reg_sel_e;
endpackage

// File: rtl/rtcb_req_dec.sv
module rtcb_req_dec
   import rtcb_pkg::*;
(
   input  logic             strobe,
   input  logic [REQ_N-1:0] ctrl_req,
   input  logic             cnt_rd_req,
   output logic [REQ_N-1:0] grant,
   output logic             snap_grant
);
   logic [REQ_N-1:0] req;
   logic [REQ_N:0]   seen;

   assign req     = ctrl_req & REQ_MASK;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < REQ_N; i++) begin : g_prio
      assign seen[i+1] = seen[i] | req[i];
      assign grant[i]  = strobe & req[i] & ~seen[i];
   end

   assign snap_grant = strobe & cnt_rd_req & ~seen[REQ_N];
endmodule

// File: rtl/rtcb_aon.sv
module rtcb_aon
   import rtcb_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [REQ_N-1:0]  grant,
   input  logic              snap_grant,
   input  logic [WORD_W-1:0] wr_word,
   output logic [WORD_W-1:0] base_q,
   output logic [WORD_W-1:0] cnt_q,
   output logic [WORD_W-1:0] sw0_q,
   output logic [WORD_W-1:0] sw1_q,
   output logic [WORD_W-1:0] snap_q,
   output logic              ret_valid,
   output logic [WORD_W-1:0] ret_word
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         sw0_q  <= '0;
         sw1_q  <= '0;
         snap_q <= '0;
      end else begin
         if (grant[B_BASE_WR]) base_q <= wr_word;
         if (grant[B_SW0_WR])  sw0_q  <= wr_word;
         if (grant[B_SW1_WR])  sw1_q  <= wr_word;
         if (grant[B_CNT_CLR])  cnt_q <= '0;
         else if (tick)         cnt_q <= cnt_q + 1'b1;
         if (snap_grant)        snap_q <= cnt_q;
      end
   end

   assign ret_valid = grant[B_BASE_RD] | grant[B_SW0_RD] | grant[B_SW1_RD];

   always_comb begin
      if (grant[B_BASE_RD])     ret_word = base_q;
      else if (grant[B_SW0_RD]) ret_word = sw0_q;
      else                      ret_word = sw1_q;
   end
endmodule

// File: rtl/rtcb_regs.sv
module rtcb_regs
   import rtcb_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 4,
   localparam int WORD_W = 2 * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              ret_valid,
   input  logic [WORD_W-1:0] ret_word,
   input  logic [WORD_W-1:0] snap_word,
   output logic [BUS_W-1:0]  ctrl_q,
   output logic [BUS_W-1:0]  ctrl2_q,
   output logic [WORD_W-1:0] wr_word,
   output logic [WORD_W-1:0] cnt_word,
   output logic [BUS_W-1:0]  rdata
);
   logic             hit;
   logic [SEL_W-1:0] sel;
   logic             trig_fire;
   logic [1:0][BUS_W-1:0] wd_q, rd_q, cn_q;

   assign sel       = addr[SEL_W-1:0];
   assign hit       = (addr >> SEL_W) == '0;
   assign trig_fire = wr_en & hit & (sel == A_TRIG) & wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ctrl2_q <= '0;
      end else if (wr_en && hit) begin
         if (sel == A_CTRL)  ctrl_q  <= wdata;
         if (sel == A_CTRL2) ctrl2_q <= wdata;
      end
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [SEL_W-1:0] WA = (h == 0) ? A_WLO : A_WHI;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wd_q[h] <= '0;
            rd_q[h] <= '0;
            cn_q[h] <= '0;
         end else begin
            if (wr_en && hit && sel == WA) wd_q[h] <= wdata;
            if (ret_valid) rd_q[h] <= ret_word[h*BUS_W +: BUS_W];
            if (trig_fire) cn_q[h] <= snap_word[h*BUS_W +: BUS_W];
         end
      end
   end

   assign wr_word  = {wd_q[1], wd_q[0]};
   assign cnt_word = {cn_q[1], cn_q[0]};

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (sel)
            A_CTRL:  rdata = ctrl_q;
            A_CTRL2: rdata = ctrl2_q;
            A_WLO:   rdata = wd_q[0];
            A_WHI:   rdata = wd_q[1];
            A_RLO:   rdata = rd_q[0];
            A_RHI:   rdata = rd_q[1];
            A_CLO:   rdata = cn_q[0];
            A_CHI:   rdata = cn_q[1];
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rtcb_top.sv
module rtcb_top
   import rtcb_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 4,
   localparam int WORD_W = 2 * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              iso_strobe,
   input  logic              sec_tick
);
   if (BUS_W < REQ_N) begin : g_bad_bus_w
      $error("BUS_W must hold all request bits");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr_w
      $error("ADDR_W too narrow for register map");
   end

   logic [BUS_W-1:0]  ctrl_q, ctrl2_q;
   logic [WORD_W-1:0] wr_word, cnt_word, ret_word;
   logic [WORD_W-1:0] aon_base, aon_cnt, aon_sw0, aon_sw1, aon_snap;
   logic [REQ_N-1:0]  grant;
   logic              snap_grant, ret_valid;

   rtcb_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .ret_valid(ret_valid), .ret_word(ret_word),
      .snap_word(aon_snap), .ctrl_q(ctrl_q), .ctrl2_q(ctrl2_q),
      .wr_word(wr_word), .cnt_word(cnt_word), .rdata(bus_rdata)
   );

   rtcb_req_dec u_dec (
      .strobe(iso_strobe), .ctrl_req(ctrl_q[REQ_N-1:0]),
      .cnt_rd_req(ctrl2_q[0]), .grant(grant), .snap_grant(snap_grant)
   );

   rtcb_aon #(.WORD_W(WORD_W)) u_aon (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .grant(grant),
      .snap_grant(snap_grant), .wr_word(wr_word), .base_q(aon_base),
      .cnt_q(aon_cnt), .sw0_q(aon_sw0), .sw1_q(aon_sw1), .snap_q(aon_snap),
      .ret_valid(ret_valid), .ret_word(ret_word)
   );
endmodule

// File: rtl/rtcb_chk.sv
module rtcb_chk
   import rtcb_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 4,
   localparam int WORD_W = 2 * BUS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iso_strobe,
   input logic              sec_tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [REQ_N-1:0]  grant,
   input logic              snap_grant,
   input logic [WORD_W-1:0] wr_word,
   input logic [WORD_W-1:0] base,
   input logic [WORD_W-1:0] cnt,
   input logic [WORD_W-1:0] sw0,
   input logic [WORD_W-1:0] sw1,
   input logic [WORD_W-1:0] snap,
   input logic [WORD_W-1:0] cnt_word
);
   logic trig_wr;
   assign trig_wr = bus_wr && (bus_addr == ADDR_W'(A_TRIG)) && bus_wdata[0];

   AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !iso_strobe |=> $stable(base) && $stable(sw0) && $stable(sw1)); // R8
   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, snap_grant})); // R9
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      grant[B_CNT_CLR] |=> cnt == '0); // R6
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick && !grant[B_CNT_CLR] |=> cnt == $past(cnt) + 1'b1); // R5
   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      grant[B_BASE_WR] |=> base == $past(wr_word)); // R2
   AST_SW0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      grant[B_SW0_WR] |=> sw0 == $past(wr_word)); // R4
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_grant |=> snap == $past(cnt)); // R7
   AST_CNTREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_wr |=> $stable(cnt_word)); // R7
   AST_CNTREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> cnt_word == $past(snap)); // R7
endmodule

bind rtcb_top rtcb_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .iso_strobe(iso_strobe), .sec_tick(sec_tick),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .grant(grant), .snap_grant(snap_grant), .wr_word(wr_word),
   .base(aon_base), .cnt(aon_cnt), .sw0(aon_sw0), .sw1(aon_sw1),
   .snap(aon_snap), .cnt_word(cnt_word)
);

// File: tb/sim_rtcb_top.sv
module sim_rtcb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        iso_strobe = 1'b0;
   logic        sec_tick = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the register-visible state
   logic [15:0] m_ctrl, m_ctrl2, m_wlo, m_whi, m_rlo, m_rhi, m_clo, m_chi;
   logic [31:0] m_base, m_cnt, m_sw0, m_sw1, m_snap;

   always #5 clk = ~clk;

   rtcb_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .iso_strobe(iso_strobe), .sec_tick(sec_tick)
   );

   function automatic int winner(logic [15:0] c);
      logic [8:0] r;
      r = c[8:0] & 9'h1EE;
      for (int i = 0; i < 9; i++) if (r[i]) return i;
      return -1;
   endfunction

   task automatic model_reset();
      m_ctrl = 0; m_ctrl2 = 0; m_wlo = 0; m_whi = 0; m_rlo = 0; m_rhi = 0;
      m_clo = 0; m_chi = 0; m_base = 0; m_cnt = 0; m_sw0 = 0; m_sw1 = 0; m_snap = 0;
   endtask

   task automatic model_step(bit wr, logic [3:0] a, logic [15:0] d, bit stb, bit tk);
      int g;
      bit sg;
      logic [31:0] w, old_snap, old_cnt;
      g = stb ? winner(m_ctrl) : -1;
      sg = stb && (g < 0) && m_ctrl2[0];
      w = {m_whi, m_wlo};
      old_snap = m_snap;
      old_cnt = m_cnt;
      case (g)
         1: m_base = w;
         2: {m_rhi, m_rlo} = m_base;
         5: m_sw0 = w;
         6: m_sw1 = w;
         7: {m_rhi, m_rlo} = m_sw0;
         8: {m_rhi, m_rlo} = m_sw1;
         default: ;
      endcase
      if (g == 3) m_cnt = 0;
      else if (tk) m_cnt = old_cnt + 1;
      if (sg) m_snap = old_cnt;
      if (wr) begin
         case (a)
            4'd0: m_ctrl = d;
            4'd1: m_ctrl2 = d;
            4'd2: if (d[0]) {m_chi, m_clo} = old_snap;
            4'd3: m_wlo = d;
            4'd4: m_whi = d;
            default: ;
         endcase
      end
   endtask

   task automatic step(bit wr, logic [3:0] a, logic [15:0] d, bit stb, bit tk);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; iso_strobe = stb; sec_tick = tk;
      @(posedge clk);
      model_step(wr, a, d, stb, tk);
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      step(1'b1, a, d, 1'b0, 1'b0);
   endtask

   task automatic strobe(bit tk);
      step(1'b0, 4'd0, 16'h0, 1'b1, tk);
   endtask

   task automatic chk(logic [3:0] a, logic [15:0] exp, string tag);
      @(negedge clk);
      bus_wr = 0; iso_strobe = 0; sec_tick = 0; bus_addr = a;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         failures++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic chk_all();
      chk(4'd0, m_ctrl, "R10");
      chk(4'd1, m_ctrl2, "R10");
      chk(4'd2, 16'h0, "R10");
      chk(4'd3, m_wlo, "R10");
      chk(4'd4, m_whi, "R10");
      chk(4'd5, m_rlo, "R3");
      chk(4'd6, m_rhi, "R3");
      chk(4'd7, m_clo, "R7");
      chk(4'd8, m_chi, "R7");
   endtask

   task automatic load_w(logic [31:0] v);
      wr(4'd3, v[15:0]);
      wr(4'd4, v[31:16]);
   endtask

   task automatic snap_and_trig();
      wr(4'd0, 16'h0);
      wr(4'd1, 16'h1);
      strobe(1'b0);
      wr(4'd1, 16'h0);
      wr(4'd2, 16'h1);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] base_v, wall;
      void'($urandom(32'h5eed_0042));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: everything zero after reset
      for (int a = 0; a < 9; a++) chk(4'(a), 16'h0, "R1");
      wr(4'd0, 16'h0080);
      strobe(1'b0);
      chk(4'd5, 16'h0, "R1 sw0 not valid");
      chk(4'd6, 16'h0, "R1 sw0 not valid");

      // R2 R6 R4: set-time sequence
      base_v = 32'h6470_1A2B;
      load_w(base_v);
      wr(4'd0, 16'h0002);
      strobe(1'b0);
      wr(4'd0, 16'h0008);
      strobe(1'b0);
      wr(4'd0, 16'h0000);
      strobe(1'b0);
      load_w(32'h1);
      wr(4'd0, 16'h0020);
      strobe(1'b0);
      wr(4'd0, 16'h0080);
      strobe(1'b0);
      chk(4'd5, 16'h0001, "R4 sw0 valid");
      chk(4'd6, 16'h0000, "R4 sw0 valid");
      wr(4'd0, 16'h0004);
      strobe(1'b0);
      chk(4'd5, base_v[15:0], "R2 base lo");
      chk(4'd6, base_v[31:16], "R2 base hi");

      // R5 R7: five ticks then two-step count read
      repeat (5) step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
      wr(4'd0, 16'h0);
      wr(4'd1, 16'h1);
      strobe(1'b0);
      wr(4'd1, 16'h0);
      chk(4'd7, 16'h0, "R7 count regs wait for trigger");
      wr(4'd2, 16'h1);
      chk(4'd7, 16'd5, "R5 count lo");
      chk(4'd8, 16'd0, "R5 count hi");
      wall = base_v + 32'd5;
      chk(4'd7, 16'(wall - base_v), "R5 wall = base + count");

      // R6: reset beats a tick in the same cycle
      wr(4'd0, 16'h0008);
      strobe(1'b1);
      snap_and_trig();
      chk(4'd7, 16'h0, "R6 reset beats tick");

      // R8: requests without strobe change nothing
      load_w(32'hDEAD_BEEF);
      wr(4'd0, 16'h0022);
      repeat (4) step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
      wr(4'd0, 16'h0080);
      strobe(1'b0);
      chk(4'd5, 16'h0001, "R8 sw0 unchanged");
      wr(4'd0, 16'h0004);
      strobe(1'b0);
      chk(4'd5, base_v[15:0], "R8 base unchanged");

      // R9: lowest bit wins; counter read yields to control request
      wr(4'd0, 16'h00A0);
      strobe(1'b0);
      chk(4'd5, base_v[15:0], "R9 read lost to write");
      wr(4'd0, 16'h0080);
      strobe(1'b0);
      chk(4'd5, 16'hBEEF, "R9 sw0 written");
      wr(4'd2, 16'h1);
      chk(4'd7, 16'h0, "R9 baseline count");
      repeat (3) step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
      wr(4'd1, 16'h1);
      wr(4'd0, 16'h0004);
      strobe(1'b0);
      wr(4'd2, 16'h1);
      chk(4'd7, 16'h0, "R9 snapshot lost to control request");
      wr(4'd0, 16'h0010);
      strobe(1'b0);
      chk(4'd5, base_v[15:0], "R9 unused bit 4 ignored");
      wr(4'd1, 16'h0);

      // R10: read-only registers ignore writes; trigger reads zero
      wr(4'd5, 16'h1111);
      wr(4'd8, 16'h2222);
      wr(4'd2, 16'hFFFE);
      chk(4'd2, 16'h0, "R10 trigger reads zero");
      chk_all();

      // random mix
      for (int n = 0; n < 300; n++) begin
         int op;
         logic [15:0] d;
         op = $urandom_range(0, 5);
         d = 16'($urandom);
         case (op)
            0: begin
               case ($urandom_range(0, 2))
                  0: begin
                     int bits[7] = '{1, 2, 3, 5, 6, 7, 8};
                     d = 16'h1 << bits[$urandom_range(0, 6)];
                  end
                  1: ;
                  default: d = 16'h0;
               endcase
               wr(4'd0, d);
            end
            1: wr(4'd1, d);
            2: wr(4'($urandom_range(3, 4)), d);
            3: step(1'($urandom_range(0, 1)), 4'($urandom_range(0, 8)), d,
                    1'b1, 1'($urandom_range(0, 1)));
            4: step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
            default: wr(4'($urandom_range(0, 1) ? 2 : $urandom_range(5, 15)), d);
         endcase
         chk_all();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule